// File: doc/BRIEF.md
# Waveform Averaging and Amplitude Histogram Engine

This block collects repeated waveform records and folds them into one result record. A record is a burst of point writes, each carrying a point position and a 10-bit vertical sample. A one-cycle end-of-record strobe closes the record. In averaging mode every point owns a 22-bit accumulator. After the programmed number of records the stored sums, shifted right by log2 of that count, form the averaged waveform. The host fetches only this one averaged record instead of every raw one.

In histogram mode the same storage holds 1024 amplitude bins, one per sample code. Each incoming sample bumps the bin of its amplitude, whatever its point position. A start pulse latches the mode and the record count and wipes the whole store. A done flag reports that the run is complete. Results are fetched through a synchronous read port with fixed latency.

Top module: `wave_avg_hist`

## Requirements
- R1: After reset `done`, `clearing` and `rd_valid` are 0, and no sample or end-of-record strobe has any effect until a start pulse is given.
- R2: A start pulse (sampled at a rising edge) raises `clearing` at the next edge and keeps it high for exactly 1024 cycles. After that every store entry reads 0.
- R3: In averaging mode (`start_hist`=0) a sample of value v at point i adds v to entry i. A read of address i then returns the entry sum shifted right by the latched log2 count.
- R4: The record count is 2^`start_log2n`. A `start_log2n` above 12 is treated as 12, so 4096 records are taken and the result is shifted by 12.
- R5: `done` rises at the edge that samples the 2^n-th end-of-record strobe of the run. It stays high until the next start pulse.
- R6: Samples and end-of-record strobes that arrive while `clearing` or `done` is high change no store entry and no flag. A sample given in the same cycle as a start pulse is also dropped.
- R7: In histogram mode (`start_hist`=1) each sample adds 1 to the entry addressed by its 10-bit value, and `smp_index` is ignored. Reads return raw counts with no shift.
- R8: An entry that holds the all-ones value of the accumulator width keeps that value on further increments instead of wrapping.
- R9: Samples to the same entry in consecutive cycles are each counted in full.
- R10: `rd_en` at an edge makes `rd_valid` high exactly two edges later, with `rd_data` holding the result for `rd_addr`. `rd_valid` is never high otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse: latch mode and count, clear the store |
| start_hist | input | 1 | Mode at start: 0 average, 1 histogram |
| start_log2n | input | 4 | log2 of the record count, clamped to 12 |
| smp_valid | input | 1 | Sample write strobe |
| smp_index | input | 9 | Point position of the sample |
| smp_value | input | 10 | Vertical sample code |
| rec_end | input | 1 | End-of-record strobe |
| rd_en | input | 1 | Result read request |
| rd_addr | input | 10 | Result entry to read |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 22 | Averaged value or bin count |
| clearing | output | 1 | Store wipe in progress |
| done | output | 1 | Programmed record count reached |

## Verification
The properties assume that `rd_en`, `start` and `rec_end` are never unknown after reset. They also assume that a start pulse followed by 1024 clear cycles with no further start is the only path out of `clearing`. The bench drives every input from a falling-edge task and holds all strobes low during reset. It issues start only as single-cycle pulses, so the clear-length, done-hold and read-latency properties see well-formed sequences. The bench also throws stray samples into the clear window and after done, which checks that the run sequencing rejects them rather than relying on the stimulus to avoid them.

// File: rtl/wah_pkg.sv
package wah_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } wah_state_e;
endpackage

// File: rtl/wah_ctrl.sv
module wah_ctrl import wah_pkg::*; #(
  parameter int DEPTH   = 1024,
  parameter int ADDR_W  = 10,
  parameter int MAX_LOG = 12,
  parameter int LOGN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_hist,
  input  logic [LOGN_W-1:0] start_log2n,
  input  logic              rec_end,
  output wah_state_e        state,
  output logic              hist,
  output logic [LOGN_W-1:0] shift,
  output logic [ADDR_W-1:0] clr_addr
);
  localparam int CNT_W = MAX_LOG + 1;

  logic [CNT_W-1:0] rec_cnt;
  logic [CNT_W-1:0] rec_last;
  logic [LOGN_W-1:0] log_clamped;

  always_comb begin
    log_clamped = (start_log2n > LOGN_W'(MAX_LOG)) ? LOGN_W'(MAX_LOG) : start_log2n;
    rec_last    = (CNT_W'(1) << shift) - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      hist     <= 1'b0;
      shift    <= '0;
      clr_addr <= '0;
      rec_cnt  <= '0;
    end else if (start) begin
      state    <= ST_CLEAR;
      hist     <= start_hist;
      shift    <= log_clamped;
      clr_addr <= '0;
      rec_cnt  <= '0;
    end else begin
      unique case (state)
        ST_CLEAR: begin
          clr_addr <= clr_addr + ADDR_W'(1);
          if (clr_addr == ADDR_W'(DEPTH - 1)) state <= ST_RUN;
        end
        ST_RUN: begin
          if (rec_end) begin
            if (rec_cnt == rec_last) state <= ST_DONE;
            else rec_cnt <= rec_cnt + CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/wah_accum.sv
module wah_accum #(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 10,
  parameter int ACC_W  = 22,
  parameter int SMP_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              accept,
  input  logic              hist,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [SMP_W-1:0]  in_val,
  input  logic              clr_we,
  input  logic [ADDR_W-1:0] clr_addr,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [ACC_W-1:0]  rd_word,
  output logic              rd_hit
);
  logic [ACC_W-1:0] mem [DEPTH];

  // stage 1 of the read-modify-write
  logic              s1_v;
  logic [ADDR_W-1:0] s1_addr;
  logic [ACC_W-1:0]  s1_inc;
  logic [ACC_W-1:0]  s1_old;
  // last accumulated write, for back-to-back forwarding
  logic              fw_v;
  logic [ADDR_W-1:0] fw_addr;
  logic [ACC_W-1:0]  fw_data;

  logic [ACC_W-1:0]  base;
  logic [ACC_W:0]    sum_wide;
  logic [ACC_W-1:0]  sum_sat;
  logic              we;
  logic [ADDR_W-1:0] wa;
  logic [ACC_W-1:0]  wd;

  always_comb begin
    base     = (fw_v && (fw_addr == s1_addr)) ? fw_data : s1_old;
    sum_wide = {1'b0, base} + {1'b0, s1_inc};
    sum_sat  = sum_wide[ACC_W] ? {ACC_W{1'b1}} : sum_wide[ACC_W-1:0];
    we       = clr_we | s1_v;
    wa       = clr_we ? clr_addr : s1_addr;
    wd       = clr_we ? '0 : sum_sat;
  end

  // storage: one write port, two synchronous read ports
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    s1_old  <= mem[in_addr];
    rd_word <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    s1_addr <= in_addr;
    s1_inc  <= hist ? ACC_W'(1) : ACC_W'(in_val);
    fw_addr <= s1_addr;
    fw_data <= sum_sat;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      s1_v <= 1'b0;
      fw_v <= 1'b0;
    end else begin
      s1_v <= accept;
      fw_v <= s1_v;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_hit <= 1'b0;
    else     rd_hit <= rd_en;
  end
endmodule

// File: rtl/wah_read.sv
module wah_read #(
  parameter int ACC_W  = 22,
  parameter int LOGN_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic [ACC_W-1:0]  word,
  input  logic              hist,
  input  logic [LOGN_W-1:0] shift,
  output logic              rd_valid,
  output logic [ACC_W-1:0]  rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= hit;
      rd_data  <= hist ? word : (word >> shift);
    end
  end
endmodule

// File: rtl/wave_avg_hist.sv
module wave_avg_hist import wah_pkg::*; #(
  parameter int PTS     = 512,
  parameter int SMP_W   = 10,
  parameter int ACC_W   = 22,
  parameter int MAX_LOG = 12,
  localparam int IDX_W  = $clog2(PTS),
  localparam int LOGN_W = $clog2(MAX_LOG + 1),
  localparam int DEPTH  = (PTS > (1 << SMP_W)) ? PTS : (1 << SMP_W),
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_hist,
  input  logic [LOGN_W-1:0] start_log2n,
  input  logic              smp_valid,
  input  logic [IDX_W-1:0]  smp_index,
  input  logic [SMP_W-1:0]  smp_value,
  input  logic              rec_end,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [ACC_W-1:0]  rd_data,
  output logic              clearing,
  output logic              done
);
  wah_state_e        state;
  logic              hist;
  logic [LOGN_W-1:0] shift;
  logic [ADDR_W-1:0] clr_addr;
  logic              accept;
  logic [ADDR_W-1:0] in_addr;
  logic [ACC_W-1:0]  rd_word;
  logic              rd_hit;

  wah_ctrl #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .MAX_LOG(MAX_LOG), .LOGN_W(LOGN_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .start_hist(start_hist),
    .start_log2n(start_log2n), .rec_end(rec_end), .state(state),
    .hist(hist), .shift(shift), .clr_addr(clr_addr)
  );

  always_comb begin
    accept   = smp_valid && (state == ST_RUN) && !start;
    in_addr  = hist ? ADDR_W'(smp_value) : ADDR_W'(smp_index);
    clearing = (state == ST_CLEAR);
    done     = (state == ST_DONE);
  end

  wah_accum #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .ACC_W(ACC_W), .SMP_W(SMP_W)
  ) u_accum (
    .clk(clk), .rst(rst), .flush(start), .accept(accept), .hist(hist),
    .in_addr(in_addr), .in_val(smp_value), .clr_we(clearing),
    .clr_addr(clr_addr), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_word(rd_word), .rd_hit(rd_hit)
  );

  wah_read #(.ACC_W(ACC_W), .LOGN_W(LOGN_W)) u_read (
    .clk(clk), .rst(rst), .hit(rd_hit), .word(rd_word), .hist(hist),
    .shift(shift), .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/wah_chk.sv
module wah_chk #(
  parameter int DEPTH = 1024
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic rec_end,
  input logic rd_en,
  input logic clearing,
  input logic done,
  input logic rd_valid
);
  int unsigned clr_len;

  always_ff @(posedge clk) begin
    if (rst || start) clr_len <= 0;
    else if (clearing) clr_len <= clr_len + 1;
  end

  // R2: start opens a wipe, never a finished run
  p_start_clears_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> (clearing && !done));

  // R2: wipe lasts exactly DEPTH cycles
  p_clear_len_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(clearing) |-> (clr_len == DEPTH));

  // R5: done only rises on an end-of-record strobe
  p_done_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(rec_end));

  // R5: done holds until a new start
  p_done_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  // R10: read answered two edges later
  p_rd_lat_r10: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> ##1 rd_valid);

  // R10: no spurious read result
  p_rd_src_r10: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en, 2));
endmodule

bind wave_avg_hist wah_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .start(start), .rec_end(rec_end), .rd_en(rd_en),
  .clearing(clearing), .done(done), .rd_valid(rd_valid)
);

// File: tb/wave_avg_hist_bench.sv
module wave_avg_hist_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        start_hist = 1'b0;
  logic [3:0]  start_log2n = '0;
  logic        smp_valid = 1'b0;
  logic [8:0]  smp_index = '0;
  logic [9:0]  smp_value = '0;
  logic        rec_end = 1'b0;
  logic        rd_en = 1'b0;
  logic [9:0]  rd_addr = '0;
  logic        rd_valid, rd_valid_s, clearing, clearing_s, done, done_s;
  logic [21:0] rd_data;
  logic [11:0] rd_data_s;

  always #4 clk = ~clk;  // 125 MHz

  wave_avg_hist u_wave_avg_hist (
    .clk(clk), .rst(rst), .start(start), .start_hist(start_hist),
    .start_log2n(start_log2n), .smp_valid(smp_valid), .smp_index(smp_index),
    .smp_value(smp_value), .rec_end(rec_end), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .clearing(clearing), .done(done)
  );

  // narrow-accumulator copy to reach the saturation point quickly
  wave_avg_hist #(.ACC_W(12)) u_wave_avg_hist_sat (
    .clk(clk), .rst(rst), .start(start), .start_hist(start_hist),
    .start_log2n(start_log2n), .smp_valid(smp_valid), .smp_index(smp_index),
    .smp_value(smp_value), .rec_end(rec_end), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid_s), .rd_data(rd_data_s), .clearing(clearing_s), .done(done_s)
  );

  typedef struct {
    int    exp_m;
    int    exp_s;
    bit    care_s;
    string req;
  } rd_item_t;

  rd_item_t sb[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int model [1024];

  task automatic check(input int act, input int exp, input string req);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic send(input int idx, input int val, input bit valid, input bit rend);
    smp_valid = valid;
    smp_index = 9'(idx);
    smp_value = 10'(val);
    rec_end   = rend;
    tick();
    smp_valid = 1'b0;
    rec_end   = 1'b0;
  endtask

  task automatic rd(input int addr, input int exp_m, input bit care_s, input int exp_s,
                    input string req);
    rd_item_t it;
    it.exp_m = exp_m; it.exp_s = exp_s; it.care_s = care_s; it.req = req;
    sb.push_back(it);
    rd_en   = 1'b1;
    rd_addr = 10'(addr);
    tick();
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  // start a run; optionally inject a stray sample in the wipe window
  task automatic do_start(input bit hist, input int log2n, input bit stray);
    int n;
    start = 1'b1; start_hist = hist; start_log2n = 4'(log2n);
    smp_valid = 1'b1; smp_index = 9'd20; smp_value = 10'd700;  // dropped: same cycle as start (R6)
    tick();
    start = 1'b0; smp_valid = 1'b0;
    n = 0;
    while (clearing) begin
      if (stray && n == 10) begin
        smp_valid = 1'b1; smp_index = 9'd20; smp_value = 10'd500;
      end else smp_valid = 1'b0;
      n++;
      tick();
    end
    smp_valid = 1'b0;
    check(n, 1024, "R2 clear length");
    for (int i = 0; i < 1024; i++) model[i] = 0;
  endtask

  // monitor: compares results as they come out
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (sb.size() == 0) begin
        check(1, 0, "R10 unexpected rd_valid");
      end else begin
        rd_item_t it;
        it = sb.pop_front();
        check(int'(rd_data), it.exp_m, it.req);
        if (it.care_s) check(int'(rd_data_s), it.exp_s, {it.req, " (narrow)"});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 1'b0;
    tick();
    // R1: reset state, strobes before any start do nothing
    check(int'(done), 0, "R1 done after reset");
    check(int'(clearing), 0, "R1 clearing after reset");
    check(int'(rd_valid), 0, "R1 rd_valid after reset");
    send(1, 300, 1, 1);
    idle(2);
    check(int'(done), 0, "R1 done unchanged by idle strobes");

    // R3/R5/R9: average over 4 records, log2n=2
    do_start(1'b0, 2, 1'b1);
    rd(20, 0, 1, 0, "R2/R6 wiped, stray clear-time sample dropped");
    rd(700, 0, 1, 0, "R2 wiped upper entry");
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 16; i++) begin
        int v;
        v = (i * 37 + r * 101) % 1024;
        model[i] += v;
        send(i, v, 1, 0);
      end
      for (int k = 0; k < 2; k++) begin  // R9 back-to-back hits on point 7
        model[7] += 200 + r;
        send(7, 200 + r, 1, 0);
      end
      model[511] += 1023;
      send(511, 1023, 1, 1);
      if (r == 2) check(int'(done), 0, "R5 done low after 3 of 4 records");
    end
    check(int'(done), 1, "R5 done after 4th record");
    // R6: strobes after done are ignored
    send(0, 999, 1, 1);
    idle(3);
    check(int'(done), 1, "R6 done unchanged after late strobe");
    for (int i = 0; i < 16; i++) rd(i, model[i] >> 2, 0, 0, "R3 averaged point");
    rd(7, model[7] >> 2, 0, 0, "R9 back-to-back point 7");
    rd(511, model[511] >> 2, 0, 0, "R3 last point");
    rd(0, model[0] >> 2, 0, 0, "R6 point 0 unchanged by late sample");
    rd(100, 0, 0, 0, "R3 untouched point");
    idle(4);

    // R4: clamp of log2n 15 to 12
    do_start(1'b0, 15, 1'b0);
    send(4, 1000, 1, 0);
    for (int r = 0; r < 4096; r++) begin
      send(3, 1023, 1, 1);
      if (r == 4094) check(int'(done), 0, "R4 done low after 4095 records");
    end
    check(int'(done), 1, "R4 done after 4096 records");
    idle(3);
    rd(3, 1023, 0, 0, "R4 shift by 12");
    rd(4, 0, 0, 0, "R4 small sum shifted out");
    idle(4);

    // R7/R8: histogram, single record
    do_start(1'b1, 0, 1'b0);
    for (int k = 0; k < 4100; k++) send(k % 512, 9, 1, 0);
    for (int k = 0; k < 3; k++) send(100 + k, 10, 1, 0);
    send(5, 0, 1, 0);
    send(6, 1023, 1, 0);
    send(6, 1023, 1, 1);
    check(int'(done), 1, "R5 histogram done after 1 record");
    idle(3);
    rd(9, 4100, 1, 4095, "R7/R8 bin 9 count, narrow saturates");
    rd(10, 3, 1, 3, "R7 bin 10");
    rd(0, 1, 1, 1, "R7 bin 0");
    rd(1023, 2, 1, 2, "R7 bin 1023 back-to-back");
    rd(100, 0, 1, 0, "R7 index ignored");
    rd(11, 0, 1, 0, "R7 empty bin");
    idle(6);
    check(sb.size(), 0, "R10 all reads answered");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule